// File: doc/BRIEF.md
# Frame Refresh Period Timer

This block paces display refresh inside a display controller. A down-counter stands in for one full frame period. When that period runs out, the block sends a one-cycle frame-done pulse to the register bank, which then sets its pending flag.

The counter only counts while the controller is enabled and no frame-done is waiting to be acknowledged. Each frame-done therefore holds refresh until software clears the pending flag. A write to the next-buffer register completes a frame at once, without waiting for the counter.

The block takes three levels and one pulse from the register bank:
- the enable level;
- the pending level;
- a one-cycle strobe for a next-buffer write.

It finds the enable edges and the software clear of the pending flag itself. It does this by comparing each level with its value in the previous cycle. The period in cycles is fixed at elaboration. It is the clock frequency times the frame time, which is 16 ms by default.

Top module: `frame_refresh_timer`

## Requirements
- R1: After reset the timer is idle (`armed_o` = 0) and `frame_done_o` is 0. It stays that way until an arming event occurs.
- R2: A rise of `run_i` while `pend_i` is 0 arms the timer for a full period of P = CLK_HZ*FRAME_US/1e6 cycles.
  - If the rise is sampled at clock edge E, `armed_o` is 1 from edge E.
  - `frame_done_o` is 1 for the cycle after edge E+P.
- R3: A rise of `run_i` while `pend_i` is 1 leaves the timer idle, and no frame-done follows.
- R4: A fall of `run_i` cancels a running count at the next edge. No frame-done follows from that count.
- R5: When `pend_i` falls from 1 to 0, the block re-evaluates arming.
  - If `run_i` is 1, a new full period starts.
  - If `run_i` is 0, the timer stays idle.
- R6: When the count expires, a frame-done is issued only if `run_i` is 1 and `pend_i` is 0 in that cycle. Otherwise the expiry is dropped and the timer goes idle.
- R7: A one-cycle `nxtbuf_i` strobe gives `frame_done_o` = 1 in the following cycle, whatever `run_i` is. It also leaves the timer idle.
- R8: `frame_done_o` lasts one cycle per event, and the timer is idle while it is high.
  - After a frame-done the timer stays idle until the next `run_i` rise or `pend_i` fall.
  - This holds even if `pend_i` never rises.
- R9: A fall of `pend_i` while a count is in progress restarts a full period from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Controller enable level from the register bank |
| pend_i | input | 1 | Frame-done pending level from the register bank |
| nxtbuf_i | input | 1 | One-cycle strobe for a next-buffer register write |
| frame_done_o | output | 1 | One-cycle frame-done event toward the pending flag |
| armed_o | output | 1 | High while the period counter is counting |

## Verification
The block is small, so a wrong internal state shows at the ports within a cycle or within one period, depending on which state is wrong.
- A stale enable or pending history register would make the block misread an edge. That fault shows at the very next edge, as `armed_o` rising or failing to rise.
- A wrong count value produces no error at arming. It shows only at expiry, as a frame-done that comes early, comes late or is missing.

The bench model therefore compares both outputs every cycle. It also walks each arming path through a full period.

// File: rtl/frame_refresh_timer.sv
module frame_refresh_timer #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned FRAME_US = 16_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pend_i,
  input  logic nxtbuf_i,
  output logic frame_done_o,
  output logic armed_o
);
  localparam longint unsigned PERIOD_CYC = (longint'(CLK_HZ) * longint'(FRAME_US)) / 64'd1000000;
  localparam int CW = (PERIOD_CYC < 2) ? 1 : $clog2(PERIOD_CYC);
  localparam logic [CW-1:0] LOAD = CW'(PERIOD_CYC - 1);

  typedef enum logic {IDLE, COUNTING} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          run_q, pend_q, done_q, done_nx;

  wire run_rise  = run_i & ~run_q;
  wire run_fall  = ~run_i & run_q;
  wire pend_fall = pend_q & ~pend_i;
  wire arm_ok    = run_i & ~pend_i;
  wire expire    = (st == COUNTING) && (cnt == '0);

  always_comb begin
    st_nx   = st;
    cnt_nx  = cnt;
    done_nx = 1'b0;
    if (nxtbuf_i) begin
      done_nx = 1'b1;
      st_nx   = IDLE;
      cnt_nx  = '0;
    end else if (run_fall) begin
      st_nx  = IDLE;
      cnt_nx = '0;
    end else if (run_rise || pend_fall) begin
      st_nx  = arm_ok ? COUNTING : IDLE;
      cnt_nx = arm_ok ? LOAD : '0;
    end else if (expire) begin
      done_nx = arm_ok;
      st_nx   = IDLE;
    end else if (st == COUNTING) begin
      cnt_nx = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_nx;
      cnt    <= cnt_nx;
      run_q  <= run_i;
      pend_q <= pend_i;
      done_q <= done_nx;
    end
  end

  assign frame_done_o = done_q;
  assign armed_o      = (st == COUNTING);

  a_r2_arm_needs_run_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> ($past(run_i) && !$past(pend_i)));

  a_r4_fall_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_i) && !nxtbuf_i) |=> !armed_o);

  a_r6_done_only_when_live: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_o && !$past(nxtbuf_i)) |-> ($past(run_i) && !$past(pend_i)));

  a_r7_nxtbuf_done: assert property (@(posedge clk) disable iff (!rst_n)
    nxtbuf_i |=> (frame_done_o && !armed_o));

  a_r8_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> !armed_o);
endmodule

// File: tb/sim_frame_refresh_timer.sv
module sim_frame_refresh_timer;
  localparam int CLK_PERIOD = 10;
  localparam int P = 12;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, pend = 1'b0, nxt = 1'b0;
  logic done, armed;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  string tag = "R1";

  bit m_armed = 0, m_done = 0, m_prun = 0, m_ppend = 0;
  int m_rem = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_refresh_timer #(.CLK_HZ(1_000_000), .FRAME_US(P)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .pend_i(pend), .nxtbuf_i(nxt),
    .frame_done_o(done), .armed_o(armed));

  always @(posedge clk) begin
    bit ok;
    ok = run && !pend;
    if (!rst_n) begin
      m_armed = 0; m_done = 0; m_prun = 0; m_ppend = 0; m_rem = 0;
    end else begin
      m_done = 0;
      if (nxt) begin
        m_done = 1; m_armed = 0;
      end else if (m_prun && !run) begin
        m_armed = 0;
      end else if ((run && !m_prun) || (m_ppend && !pend)) begin
        m_armed = ok; m_rem = P;
      end else if (m_armed) begin
        if (m_rem == 1) begin
          m_done = ok; m_armed = 0;
        end else m_rem--;
      end
      m_prun = run; m_ppend = pend;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (done !== m_done || armed !== m_armed) begin
        fails++;
        $display("FAIL %s cycle %0d: done=%b armed=%b expected done=%b armed=%b",
                 tag, cyc, done, armed, m_done, m_armed);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    tag = "R1";
    check("R1 idle", armed, 1'b0);
    check("R1 done", done, 1'b0);

    tag = "R2";
    run = 1'b1;
    cycles(P);
    check("R2 not early", done, 1'b0);
    cycles(1);
    check("R2 done at period", done, 1'b1);

    tag = "R8";
    cycles(1);
    check("R8 one cycle", done, 1'b0);
    cycles(P + 3);
    check("R8 stays idle", armed, 1'b0);

    tag = "R5";
    pend = 1'b1; cycles(2);
    pend = 1'b0;
    cycles(1);
    check("R5 rearm", armed, 1'b1);
    cycles(P);
    check("R5 done", done, 1'b1);
    pend = 1'b1; cycles(2);
    run = 1'b0; cycles(2);
    pend = 1'b0; cycles(2);
    check("R5 no arm while stopped", armed, 1'b0);

    tag = "R3";
    pend = 1'b1; cycles(1);
    run = 1'b1; cycles(2);
    check("R3 no arm while pending", armed, 1'b0);
    cycles(P + 2);
    check("R3 no done", done, 1'b0);

    tag = "R4";
    pend = 1'b0; cycles(5);
    run = 1'b0; cycles(1);
    check("R4 cancelled", armed, 1'b0);
    cycles(P + 2);

    tag = "R6";
    run = 1'b1; cycles(4);
    pend = 1'b1;
    cycles(P + 2);
    check("R6 expiry dropped", armed, 1'b0);

    tag = "R9";
    pend = 1'b0; run = 1'b0; cycles(2);
    run = 1'b1; cycles(6);
    pend = 1'b1; cycles(2);
    pend = 1'b0;
    cycles(P);
    check("R9 restarted", done, 1'b0);
    cycles(1);
    check("R9 done after restart", done, 1'b1);

    tag = "R7";
    pend = 1'b1; run = 1'b0; cycles(2);
    nxt = 1'b1; cycles(1); nxt = 1'b0;
    check("R7 done while stopped", done, 1'b1);
    pend = 1'b0; cycles(2);
    run = 1'b1; cycles(4);
    nxt = 1'b1; cycles(1); nxt = 1'b0;
    check("R7 done mid count", done, 1'b1);
    check("R7 idle", armed, 1'b0);
    cycles(P + 2);
    summary();
  end
endmodule